// File: doc/BRIEF.md
# Masked Block-Fill Column Memory

This block is a small synchronous column memory whose write path offers two kinds of write. A normal write stores the 32-bit data bus into one addressed column, under a per-byte mask. A block write fills a group of eight consecutive columns, aligned to an eight-column boundary, in a single cycle. The data comes from an internal colour register, and the data bus is read as a per-column, per-byte-lane select pattern.

The colour register is loaded by its own command, which captures the data bus. Block writes must be spaced by a programmable number of clocks. A block write issued before that spacing has elapsed is dropped and flagged for one cycle. A one-column read port with one cycle of latency gives visibility into the stored contents.

Top module: `blkfill_mem`

## Requirements
- R1: A normal write (`wr_en`=1, `fill_en`=0, `load_en`=0) stores `dq` into column `col_addr`. Byte lane k (bits 8k+7..8k) is written only when `byte_mask[k]`=0; a lane whose mask bit is 1 keeps its old value.
- R2: `rd_data` shows the word stored at `rd_addr` one clock after the address is applied. After reset the memory, the colour register, `rd_data` and `fill_reject` are all zero.
- R3: A block write (`wr_en`=1, `fill_en`=1) covers columns 8*floor(`col_addr`/8) through that value plus 7. Address bits [2:0] are ignored.
- R4: A block write stores the colour register, not `dq`. Columns outside the addressed group are unchanged.
- R5: During a block write, `dq` bit 8k+c enables column c of the group (c=0..7) for byte lane k. Lane k of column c is written only when that bit is 1 and `byte_mask[k]`=0. The byte mask applies to all eight columns.
- R6: A block write is accepted only when at least `FILL_GAP` clocks have passed since the last accepted block write (issue cycles t and t+`FILL_GAP` are both accepted). Normal writes are never held back by this spacing.
- R7: A block write issued too early changes no column and raises `fill_reject` for exactly the following clock cycle.
- R8: `load_en`=1 captures `dq` into the colour register. When `load_en` and `wr_en` are both 1 in the same cycle, only the load happens: no column changes and `fill_reject` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Load colour register from `dq` |
| wr_en | input | 1 | Write command |
| fill_en | input | 1 | With `wr_en`: 1 selects block write, 0 selects normal write |
| col_addr | input | 6 | Write column address |
| dq | input | 32 | Write data, or column-select pattern during a block write |
| byte_mask | input | 4 | Per-lane write mask, 1 = lane kept |
| rd_addr | input | 6 | Read column address |
| rd_data | output | 32 | Stored word at the read address, one cycle later |
| fill_reject | output | 1 | One-cycle pulse after a block write dropped for spacing |

## Verification
A wrong spacing counter shows up at the ports as soon as the next block write is issued. It gives either a `fill_reject` pulse where none is due, or a group of columns that changes when it should not, and both are visible one and two cycles after the command. A stale or corrupted colour register shows up in every column a later block write touches. A wrong lane or column decode puts bytes in the wrong places, which the read-back of all eight columns of the group exposes. The neighbouring group is read too, to catch writes that spill over.

// File: rtl/blkfill_pkg.sv
package blkfill_pkg;
  // Columns per block-fill group; behaviour depends on this being 8.
  localparam int unsigned GROUP_COLS = 8;
  localparam int unsigned GROUP_BITS = $clog2(GROUP_COLS);
  localparam int unsigned LANE_W     = 8;
endpackage

// File: rtl/blkfill_gap.sv
module blkfill_gap #(
  parameter int unsigned FILL_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ok
);
  localparam int unsigned CW = (FILL_GAP < 2) ? 1 : $clog2(FILL_GAP);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign ok = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (req && ok) begin
      cnt_d  = CW'(FILL_GAP - 1);
      cnt_en = 1'b1;
    end else if (!ok) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (FILL_GAP > 1) begin : g_gap_chk
      // R6: an accepted fill closes the window for the next cycle
      a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ok) |=> !ok);
    end
  endgenerate
endmodule

// File: rtl/blkfill_lanemask.sv
module blkfill_lanemask
  import blkfill_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = DW / LANE_W
) (
  input  logic                                  fill_mode,
  input  logic [GROUP_BITS-1:0]                 col_lo,
  input  logic [DW-1:0]                         dq,
  input  logic [LANES-1:0]                      byte_mask,
  output logic [GROUP_COLS-1:0][LANES-1:0]      en
);
  always_comb begin
    for (int c = 0; c < GROUP_COLS; c++) begin
      for (int k = 0; k < LANES; k++) begin
        if (fill_mode)
          en[c][k] = dq[k*LANE_W + c] & ~byte_mask[k];
        else
          en[c][k] = (col_lo == GROUP_BITS'(c)) & ~byte_mask[k];
      end
    end
  end
endmodule

// File: rtl/blkfill_array.sv
module blkfill_array
  import blkfill_pkg::*;
#(
  parameter int unsigned COLS  = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = DW / LANE_W,
  parameter int unsigned AW    = $clog2(COLS),
  parameter int unsigned GW    = AW - GROUP_BITS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [GW-1:0]                    grp_sel,
  input  logic [GROUP_COLS-1:0][LANES-1:0] en,
  input  logic [DW-1:0]                    wdata,
  input  logic [AW-1:0]                    rd_addr,
  output logic [DW-1:0]                    rd_data
);
  logic [COLS-1:0][DW-1:0]    mem_q;
  logic [COLS-1:0][LANES-1:0] wen;

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      for (int k = 0; k < LANES; k++) begin
        wen[c][k] = we && (grp_sel == GW'(c / GROUP_COLS)) &&
                    en[c % GROUP_COLS][k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        for (int k = 0; k < LANES; k++) begin
          if (wen[c][k]) mem_q[c][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem_q[rd_addr];
  end

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_hold_chk
      // R4: a column with no lane enabled keeps its contents
      a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wen[c]) |=> $stable(mem_q[c]));
    end
  endgenerate
endmodule

// File: rtl/blkfill_mem.sv
module blkfill_mem
  import blkfill_pkg::*;
#(
  parameter int unsigned COLS     = 64,
  parameter int unsigned DW       = 32,
  parameter int unsigned FILL_GAP = 3,
  localparam int unsigned LANES   = DW / LANE_W,
  localparam int unsigned AW      = $clog2(COLS),
  localparam int unsigned GW      = AW - GROUP_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             wr_en,
  input  logic             fill_en,
  input  logic [AW-1:0]    col_addr,
  input  logic [DW-1:0]    dq,
  input  logic [LANES-1:0] byte_mask,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             fill_reject
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  // command decode, load wins over write
  logic wr_go, fill_req, fill_ok, fill_go, norm_go, we;

  assign wr_go    = wr_en & ~load_en;
  assign fill_req = wr_go & fill_en;
  assign norm_go  = wr_go & ~fill_en;
  assign fill_go  = fill_req & fill_ok;
  assign we       = norm_go | fill_go;

  blkfill_gap #(.FILL_GAP(FILL_GAP)) i_gap (
    .clk   (clk),
    .rst_n (srst_n),
    .req   (fill_req),
    .ok    (fill_ok)
  );

  // colour register
  logic [DW-1:0] colour_q, colour_d;

  always_comb begin
    colour_d = colour_q;
    if (load_en) colour_d = dq;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      colour_q <= '0;
    else if (load_en) colour_q <= colour_d;
  end

  // reject flag
  logic rej_d;
  assign rej_d = fill_req & ~fill_ok;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) fill_reject <= 1'b0;
    else         fill_reject <= rej_d;
  end

  // lane/column enables and storage
  logic [GROUP_COLS-1:0][LANES-1:0] en;

  blkfill_lanemask #(.DW(DW), .LANES(LANES)) i_mask (
    .fill_mode (fill_en),
    .col_lo    (col_addr[GROUP_BITS-1:0]),
    .dq        (dq),
    .byte_mask (byte_mask),
    .en        (en)
  );

  blkfill_array #(.COLS(COLS), .DW(DW), .LANES(LANES), .AW(AW), .GW(GW)) i_array (
    .clk     (clk),
    .rst_n   (srst_n),
    .we      (we),
    .grp_sel (col_addr[AW-1:GROUP_BITS]),
    .en      (en),
    .wdata   (fill_en ? colour_q : dq),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R7: a reject pulse always follows a block write command
  a_r7_reject_cause: assert property (@(posedge clk) disable iff (!srst_n)
    fill_reject |-> $past(wr_en && fill_en && !load_en));

  // R8: the load captures the bus
  a_r8_load: assert property (@(posedge clk) disable iff (!srst_n)
    load_en |=> (colour_q == $past(dq)));

  // R8: without a load the colour is kept
  a_r8_keep: assert property (@(posedge clk) disable iff (!srst_n)
    !load_en |=> $stable(colour_q));
endmodule

// File: tb/test_blkfill_mem.sv
module test_blkfill_mem;
  localparam int CLK_PERIOD = 10;
  localparam int TBWC       = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en, wr_en, fill_en;
  logic [5:0]  col_addr, rd_addr;
  logic [31:0] dq;
  logic [3:0]  byte_mask;
  logic [31:0] rd_data;
  logic        fill_reject;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkfill_mem #(.COLS(64), .DW(32), .FILL_GAP(TBWC)) i_blkfill_mem (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .wr_en(wr_en), .fill_en(fill_en),
    .col_addr(col_addr), .dq(dq), .byte_mask(byte_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .fill_reject(fill_reject)
  );

  int nchk  = 0;
  int nfail = 0;
  logic [31:0] mdl [64];
  logic [31:0] mcol;
  int tcyc    = 0;
  int last_bw = -100;
  logic exp_rej;

  // op: 0 idle, 1 load colour, 2 normal write, 3 block write
  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [31:0] d;
    logic [3:0]  bm;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{2'd1, 6'd0,  32'hA5C3_0F11, 4'h0},
    '{2'd2, 6'd3,  32'h1234_5678, 4'h0},
    '{2'd2, 6'd3,  32'hFFFF_FFFF, 4'b0101},
    '{2'd3, 6'd13, 32'hFFFF_FFFF, 4'h0},
    '{2'd3, 6'd0,  32'h8040_2001, 4'h0},
    '{2'd1, 6'd0,  32'hDEAD_BEEF, 4'h0},
    '{2'd3, 6'd7,  32'hFFFF_FFFF, 4'b1001},
    '{2'd3, 6'd63, 32'h0F0F_F0F0, 4'h0},
    '{2'd2, 6'd60, 32'hCAFE_0001, 4'b1110},
    '{2'd2, 6'd8,  32'h0000_0000, 4'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus; also updates the bench model from the requirements
  task automatic drive(input logic ld, input logic wr, input logic fl,
                       input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    load_en = ld; wr_en = wr; fill_en = fl; col_addr = a; dq = d; byte_mask = b;
    exp_rej = 1'b0;
    if (ld) begin
      mcol = d;
    end else if (wr && fl) begin
      if (tcyc - last_bw >= TBWC) begin
        last_bw = tcyc;
        for (int c = 0; c < 8; c++)
          for (int k = 0; k < 4; k++)
            if (d[8*k + c] && !b[k]) mdl[int'(a[5:3])*8 + c][8*k +: 8] = mcol[8*k +: 8];
      end else begin
        exp_rej = 1'b1;
      end
    end else if (wr) begin
      for (int k = 0; k < 4; k++)
        if (!b[k]) mdl[a][8*k +: 8] = d[8*k +: 8];
    end
    tcyc++;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 6'd0, 32'h0, 4'h0);
  endtask

  task automatic read_chk(input string tag, input int col);
    rd_addr = 6'(col);
    idle();
    chk(tag, rd_data, mdl[col]);
  endtask

  task automatic group_chk(input string tag, input logic [5:0] a);
    for (int c = 0; c < 8; c++) read_chk(tag, int'(a[5:3])*8 + c);
    read_chk("R4 neighbour group", (int'(a[5:3]) ^ 1)*8);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mcol = '0;
    load_en = 0; wr_en = 0; fill_en = 0; col_addr = 0; dq = 0; byte_mask = 0; rd_addr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset rd_data", rd_data, 32'h0);
    chk("R2 reset fill_reject", {31'h0, fill_reject}, 32'h0);
    rst_n = 1'b1;
    repeat (4) idle();
    read_chk("R2 memory cleared", 5);
    read_chk("R2 memory cleared", 63);

    // table walk
    for (int v = 0; v < 10; v++) begin
      case (TBL[v].op)
        2'd1: drive(1'b1, 1'b0, 1'b0, TBL[v].addr, TBL[v].d, TBL[v].bm);
        2'd2: drive(1'b0, 1'b1, 1'b0, TBL[v].addr, TBL[v].d, TBL[v].bm);
        2'd3: drive(1'b0, 1'b1, 1'b1, TBL[v].addr, TBL[v].d, TBL[v].bm);
        default: idle();
      endcase
      chk("R7 no reject in table", {31'h0, fill_reject}, {31'h0, exp_rej});
      repeat (TBWC) idle();
      case (TBL[v].op)
        2'd2: group_chk("R1 normal write", TBL[v].addr);
        2'd3: group_chk("R3 R5 block write", TBL[v].addr);
        default: group_chk("R8 load leaves memory", TBL[v].addr);
      endcase
    end

    // spacing: accepted, too early, gap exactly TBWC
    drive(1'b1, 1'b0, 1'b0, 6'd0, 32'h1111_1111, 4'h0);
    repeat (TBWC) idle();
    drive(1'b0, 1'b1, 1'b1, 6'd16, 32'hFFFF_FFFF, 4'h0);
    chk("R6 first fill accepted", {31'h0, fill_reject}, 32'h0);
    drive(1'b0, 1'b1, 1'b1, 6'd32, 32'hFFFF_FFFF, 4'h0);
    chk("R7 early fill flagged", {31'h0, fill_reject}, 32'h1);
    idle();
    chk("R7 flag lasts one cycle", {31'h0, fill_reject}, 32'h0);
    drive(1'b0, 1'b1, 1'b1, 6'd40, 32'hFFFF_FFFF, 4'h0);
    chk("R6 fill at exact gap accepted", {31'h0, fill_reject}, 32'h0);
    drive(1'b0, 1'b1, 1'b0, 6'd33, 32'h5A5A_5A5A, 4'h0);
    chk("R6 normal write inside window", {31'h0, fill_reject}, 32'h0);
    repeat (TBWC) idle();
    read_chk("R7 rejected fill left column", 32);
    read_chk("R7 rejected fill left column", 39);
    read_chk("R6 normal write inside window", 33);
    read_chk("R6 fill at exact gap", 40);
    read_chk("R6 fill at exact gap", 47);
    read_chk("R6 first fill", 23);

    // load and write together: load wins
    drive(1'b1, 1'b1, 1'b0, 6'd50, 32'h7777_7777, 4'h0);
    chk("R8 load priority no reject", {31'h0, fill_reject}, 32'h0);
    read_chk("R8 write dropped under load", 50);
    repeat (TBWC) idle();
    drive(1'b1, 1'b1, 1'b1, 6'd48, 32'h0000_00FF, 4'h0);
    chk("R8 load over fill no reject", {31'h0, fill_reject}, 32'h0);
    read_chk("R8 fill dropped under load", 48);
    drive(1'b0, 1'b1, 1'b1, 6'd49, 32'hFFFF_FFFF, 4'h0);
    repeat (TBWC) idle();
    group_chk("R8 R4 colour from load", 6'd48);

    finish_run();
  end
endmodule